// File: doc/BRIEF.md
# Multi-Bank Programmable Clock Divider

This block produces three banks of complementary divided clocks from one selected source. It runs on a single fast core clock. Each source clock arrives as a one-cycle tick strobe, high in the core cycle that follows that source's rising edge. Two reference strobes and one oscillator strobe are available. A two-stage selection first picks one of the two references, then picks either that reference or the oscillator. The chosen strobe then drives every divider.

Bank A has four output pairs and bank B has four. The feedback bank has two. Within a bank every pair carries the same clock, and each bank's even ratio is set by its own small select bus. An active-high master reset holds all dividers idle. Once the reset is released, the first selected tick raises every bank's output together, so the rising edges of all banks share a common origin.

Each bank is driven by a three-state machine:
- ARMED: the state held under reset. It tracks the select bus.
- ARMED to HI: taken on the first tick after the reset is released. The ratio is latched here.
- HI to LO: taken after half the ratio in ticks.
- LO to HI: taken after another half ratio. This is the wrap point, and the select bus is sampled again here.

Top module: `clk_div_banks`

## Requirements
- R1: Bank A ratio from `sel_a`: code 0 gives /2, code 1 gives /4, code 2 gives /6, code 3 gives /8, counted in selected ticks.
- R2: Bank B ratio from `sel_b`: code 0 gives /2, code 1 gives /4, code 2 gives /8, code 3 gives /12.
- R3: Feedback bank ratio from `sel_fb`: codes 0 to 7 give /4, /6, /8, /10, /8, /12, /16, /20.
- R4: In the cycle after any clock edge at which `mr` is high, every true output is 0 and every complementary output is 1.
- R5: With `src_sel` high the dividers count `osc_tick`. With it low they count the chosen reference. An unselected strobe moves no output.
- R6: With `src_sel` low, `in_sel` low picks `ref0_tick` and `in_sel` high picks `ref1_tick`.
- R7: All pairs of one bank carry the same value in every cycle.
- R8: Each output stays high for exactly N/2 ticks and low for exactly N/2 ticks, which gives a 50% duty cycle.
- R9: After `mr` is released, the first selected tick drives the true output of every bank high in the same cycle.
- R10: A select change takes effect only at the next LO-to-HI wrap, or while the bank is ARMED. The running period always completes at its old ratio.
- R11: Every complementary output is the exact inverse of its true output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| mr | input | 1 | Master reset, active high, synchronous |
| in_sel | input | 1 | Reference pick: 0 selects ref0, 1 selects ref1 |
| src_sel | input | 1 | Source pick: 0 selects the reference, 1 selects the oscillator |
| ref0_tick | input | 1 | Edge strobe of the first reference |
| ref1_tick | input | 1 | Edge strobe of the second reference |
| osc_tick | input | 1 | Edge strobe of the oscillator |
| sel_a | input | 2 | Bank A ratio code |
| sel_b | input | 2 | Bank B ratio code |
| sel_fb | input | 3 | Feedback bank ratio code |
| qa | output | A_PAIRS | Bank A true outputs |
| qa_n | output | A_PAIRS | Bank A complementary outputs |
| qb | output | B_PAIRS | Bank B true outputs |
| qb_n | output | B_PAIRS | Bank B complementary outputs |
| qfb | output | FB_PAIRS | Feedback bank true outputs |
| qfb_n | output | FB_PAIRS | Feedback bank complementary outputs |

## Verification
A tick sampled at a rising core edge changes the state register at that edge, so the outputs show the result one edge after the tick. A reset edge clears the outputs at that same edge. The bench updates its behavioural model at each rising edge from the inputs it drove at the previous falling edge. It compares every output at the following falling edge, which is exactly where each result is due. Phase lengths and periods are counted in falling-edge samples, so a /N ratio on a source that ticks every k core cycles must show N*k samples between rising edges.

// File: rtl/clk_div_pkg.sv
package clk_div_pkg;

    localparam int HALF_W   = 4;
    localparam int MAX_HALF = 10;

    typedef enum logic [1:0] {
        S_ARMED = 2'd0,
        S_HI    = 2'd1,
        S_LO    = 2'd2
    } div_state_t;

    typedef enum logic [1:0] {
        KIND_A  = 2'd0,
        KIND_B  = 2'd1,
        KIND_FB = 2'd2
    } bank_kind_t;

    // Half of the divide ratio, in source ticks, for a bank kind and code.
    function automatic logic [HALF_W-1:0] half_of(bank_kind_t kind, logic [2:0] code);
        logic [HALF_W-1:0] h;
        h = HALF_W'(1);
        unique case (kind)
            KIND_A: begin
                unique case (code[1:0])
                    2'd0: h = HALF_W'(1);
                    2'd1: h = HALF_W'(2);
                    2'd2: h = HALF_W'(3);
                    default: h = HALF_W'(4);
                endcase
            end
            KIND_B: begin
                unique case (code[1:0])
                    2'd0: h = HALF_W'(1);
                    2'd1: h = HALF_W'(2);
                    2'd2: h = HALF_W'(4);
                    default: h = HALF_W'(6);
                endcase
            end
            default: begin
                unique case (code)
                    3'd0: h = HALF_W'(2);
                    3'd1: h = HALF_W'(3);
                    3'd2: h = HALF_W'(4);
                    3'd3: h = HALF_W'(5);
                    3'd4: h = HALF_W'(4);
                    3'd5: h = HALF_W'(6);
                    3'd6: h = HALF_W'(8);
                    default: h = HALF_W'(10);
                endcase
            end
        endcase
        return h;
    endfunction

endpackage

// File: rtl/clk_src_pick.sv
module clk_src_pick (
    input  logic ref0_tick,
    input  logic ref1_tick,
    input  logic osc_tick,
    input  logic in_sel,
    input  logic src_sel,
    output logic tick
);
    logic ref_tick;

    // First level: choose between the two references.
    always_comb begin
        unique case (in_sel)
            1'b0:    ref_tick = ref0_tick;
            default: ref_tick = ref1_tick;
        endcase
    end

    // Second level: reference (bypass) or oscillator.
    always_comb begin
        unique case (src_sel)
            1'b0:    tick = ref_tick;
            default: tick = osc_tick;
        endcase
    end
endmodule

// File: rtl/clk_div_bank.sv
module clk_div_bank
    import clk_div_pkg::*;
#(
    parameter bank_kind_t KIND  = KIND_A,
    parameter int         SEL_W = 2,
    parameter int         PAIRS = 4
) (
    input  logic             clk,
    input  logic             mr,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel,
    output logic [PAIRS-1:0] q,
    output logic [PAIRS-1:0] q_n
);
    localparam logic [HALF_W-1:0] ONE = HALF_W'(1);

    div_state_t        state, state_nx;
    logic [HALF_W-1:0] cnt, cnt_nx;
    logic [HALF_W-1:0] half, half_nx;
    logic [2:0]        code_ext;
    logic [HALF_W-1:0] dec_half;
    logic              last_tick;
    logic              level;

    always_comb begin
        code_ext = '0;
        code_ext[SEL_W-1:0] = sel;
    end

    assign dec_half  = half_of(KIND, code_ext);
    assign last_tick = (cnt == half - ONE);

    // State register.
    always_ff @(posedge clk) begin
        if (mr) begin
            state <= S_ARMED;
            cnt   <= '0;
            half  <= dec_half;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
            half  <= half_nx;
        end
    end

    // Next-state logic.
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        half_nx  = half;
        unique case (state)
            S_ARMED: begin
                half_nx = dec_half;
                if (tick) begin
                    state_nx = S_HI;
                    cnt_nx   = '0;
                end
            end
            S_HI: begin
                if (tick) begin
                    if (last_tick) begin
                        state_nx = S_LO;
                        cnt_nx   = '0;
                    end else begin
                        cnt_nx = cnt + ONE;
                    end
                end
            end
            S_LO: begin
                if (tick) begin
                    if (last_tick) begin
                        state_nx = S_HI;
                        cnt_nx   = '0;
                        half_nx  = dec_half;
                    end else begin
                        cnt_nx = cnt + ONE;
                    end
                end
            end
            default: begin
                state_nx = S_ARMED;
                cnt_nx   = '0;
            end
        endcase
    end

    // Output decode.
    always_comb begin
        unique case (state)
            S_HI:    level = 1'b1;
            default: level = 1'b0;
        endcase
    end

    for (genvar i = 0; i < PAIRS; i++) begin : g_pair
        assign q[i]   = level;
        assign q_n[i] = ~level;
    end
endmodule

// File: rtl/clk_div_banks.sv
module clk_div_banks
    import clk_div_pkg::*;
#(
    parameter int A_PAIRS  = 4,
    parameter int B_PAIRS  = 4,
    parameter int FB_PAIRS = 2
) (
    input  logic                clk,
    input  logic                mr,
    input  logic                in_sel,
    input  logic                src_sel,
    input  logic                ref0_tick,
    input  logic                ref1_tick,
    input  logic                osc_tick,
    input  logic [1:0]          sel_a,
    input  logic [1:0]          sel_b,
    input  logic [2:0]          sel_fb,
    output logic [A_PAIRS-1:0]  qa,
    output logic [A_PAIRS-1:0]  qa_n,
    output logic [B_PAIRS-1:0]  qb,
    output logic [B_PAIRS-1:0]  qb_n,
    output logic [FB_PAIRS-1:0] qfb,
    output logic [FB_PAIRS-1:0] qfb_n
);
    logic src_tick;

    clk_src_pick u_pick (
        .ref0_tick (ref0_tick),
        .ref1_tick (ref1_tick),
        .osc_tick  (osc_tick),
        .in_sel    (in_sel),
        .src_sel   (src_sel),
        .tick      (src_tick)
    );

    clk_div_bank #(.KIND(KIND_A), .SEL_W(2), .PAIRS(A_PAIRS)) u_bank_a (
        .clk (clk), .mr (mr), .tick (src_tick), .sel (sel_a),
        .q (qa), .q_n (qa_n)
    );

    clk_div_bank #(.KIND(KIND_B), .SEL_W(2), .PAIRS(B_PAIRS)) u_bank_b (
        .clk (clk), .mr (mr), .tick (src_tick), .sel (sel_b),
        .q (qb), .q_n (qb_n)
    );

    clk_div_bank #(.KIND(KIND_FB), .SEL_W(3), .PAIRS(FB_PAIRS)) u_bank_fb (
        .clk (clk), .mr (mr), .tick (src_tick), .sel (sel_fb),
        .q (qfb), .q_n (qfb_n)
    );
endmodule

// File: rtl/clk_div_banks_chk.sv
module clk_div_banks_chk
    import clk_div_pkg::*;
#(
    parameter int A_PAIRS  = 4,
    parameter int B_PAIRS  = 4,
    parameter int FB_PAIRS = 2
) (
    input logic                clk,
    input logic                mr,
    input logic                tick,
    input logic [A_PAIRS-1:0]  qa,
    input logic [A_PAIRS-1:0]  qa_n,
    input logic [B_PAIRS-1:0]  qb,
    input logic [B_PAIRS-1:0]  qb_n,
    input logic [FB_PAIRS-1:0] qfb,
    input logic [FB_PAIRS-1:0] qfb_n
);
    logic       armed = 1'b0;
    logic       fresh = 1'b0;
    logic       fb_prev = 1'b0;
    logic [4:0] fb_hold = '0;

    always_ff @(posedge clk) armed <= 1'b1;

    always_ff @(posedge clk) begin
        if (mr)        fresh <= 1'b1;
        else if (tick) fresh <= 1'b0;
    end

    always_ff @(posedge clk) begin
        fb_prev <= qfb[0];
        if (mr)                   fb_hold <= '0;
        else if (qfb[0] != fb_prev) fb_hold <= tick ? 5'd1 : 5'd0;
        else if (tick)            fb_hold <= fb_hold + 5'd1;
    end

    // R4
    reset_state_chk: assert property (@(posedge clk) disable iff (!armed)
        $past(mr) |-> (qa == '0 && qb == '0 && qfb == '0 &&
                       qa_n == {A_PAIRS{1'b1}} && qb_n == {B_PAIRS{1'b1}} &&
                       qfb_n == {FB_PAIRS{1'b1}}));

    // R5
    quiet_chk: assert property (@(posedge clk) disable iff (mr)
        (!$past(mr) && !$past(tick)) |-> ($stable(qa) && $stable(qb) && $stable(qfb)));

    // R9
    first_edge_chk: assert property (@(posedge clk) disable iff (mr)
        ($past(fresh) && $past(tick) && !$past(mr)) |-> (qa[0] && qb[0] && qfb[0]));

    // R8
    fb_hold_chk: assert property (@(posedge clk) disable iff (mr)
        fb_hold <= 5'(MAX_HALF));
endmodule

bind clk_div_banks clk_div_banks_chk #(
    .A_PAIRS(A_PAIRS), .B_PAIRS(B_PAIRS), .FB_PAIRS(FB_PAIRS)
) u_chk (
    .clk (clk), .mr (mr), .tick (src_tick),
    .qa (qa), .qa_n (qa_n), .qb (qb), .qb_n (qb_n),
    .qfb (qfb), .qfb_n (qfb_n)
);

// File: tb/sim_clk_div_banks.sv
module sim_clk_div_banks;
    logic       clk = 1'b0;
    logic       mr = 1'b1;
    logic       in_sel = 1'b0;
    logic       src_sel = 1'b1;
    logic       r0 = 1'b0, r1 = 1'b0, osc = 1'b0;
    logic [1:0] sel_a = 2'd0, sel_b = 2'd0;
    logic [2:0] sel_fb = 3'd0;
    logic [3:0] qa, qa_n, qb, qb_n;
    logic [1:0] qfb, qfb_n;

    int total = 0, fails = 0, cyc = 0;
    bit cmp_on = 1'b0;
    string ptag = "R1";

    clk_div_banks u0 (
        .clk(clk), .mr(mr), .in_sel(in_sel), .src_sel(src_sel),
        .ref0_tick(r0), .ref1_tick(r1), .osc_tick(osc),
        .sel_a(sel_a), .sel_b(sel_b), .sel_fb(sel_fb),
        .qa(qa), .qa_n(qa_n), .qb(qb), .qb_n(qb_n), .qfb(qfb), .qfb_n(qfb_n)
    );

    always #10 clk = ~clk;

    task automatic check(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            check(1'b0, "R8 watchdog", cyc, 150000);
            finish_run();
        end
    end

    // Source strobes: ref0 every 3 cycles, ref1 every 5, oscillator every cycle.
    int c0 = 0, c1 = 0;
    always @(negedge clk) begin
        c0 = (c0 == 2) ? 0 : c0 + 1;
        c1 = (c1 == 4) ? 0 : c1 + 1;
        r0 = (c0 == 0);
        r1 = (c1 == 0);
        osc = 1'b1;
    end

    // Behavioural reference model.
    function automatic int ratio_of(int b, int code);
        if (b == 0) return 2 * (code + 1);
        if (b == 1) return (code < 2) ? 2 * (code + 1) : ((code == 2) ? 8 : 12);
        return (code >= 4 ? 2 : 1) * (4 + 2 * (code % 4));
    endfunction

    function automatic int code_of(int b);
        return (b == 0) ? int'(sel_a) : ((b == 1) ? int'(sel_b) : int'(sel_fb));
    endfunction

    bit lvl[3];
    bit started[3];
    int left[3];
    int hlf[3];

    always @(posedge clk) begin
        bit t;
        t = src_sel ? osc : (in_sel ? r1 : r0);
        for (int b = 0; b < 3; b++) begin
            if (mr) begin
                started[b] = 1'b0;
                lvl[b] = 1'b0;
            end else if (t) begin
                if (!started[b]) begin
                    started[b] = 1'b1;
                    lvl[b] = 1'b1;
                    hlf[b] = ratio_of(b, code_of(b)) / 2;
                    left[b] = hlf[b];
                end else begin
                    left[b]--;
                    if (left[b] == 0) begin
                        lvl[b] = !lvl[b];
                        if (lvl[b]) hlf[b] = ratio_of(b, code_of(b)) / 2;
                        left[b] = hlf[b];
                    end
                end
            end
        end
    end

    // Per-cycle comparison at the falling edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            check(qa == {4{lvl[0]}}, {"R1 bank A vs model ", ptag}, int'(qa), lvl[0] ? 15 : 0);
            check(qb == {4{lvl[1]}}, {"R2 bank B vs model ", ptag}, int'(qb), lvl[1] ? 15 : 0);
            check(qfb == {2{lvl[2]}}, {"R3 feedback vs model ", ptag}, int'(qfb), lvl[2] ? 3 : 0);
            check((qa == '0 || qa == '1) && (qb == '0 || qb == '1) && (qfb == '0 || qfb == '1),
                  "R7 pairs equal", int'(qa), 0);
            check(qa_n == ~qa && qb_n == ~qb && qfb_n == ~qfb, "R11 complement",
                  int'(qa_n), int'(~qa));
        end
    end

    function automatic bit tru(int b);
        return (b == 0) ? qa[0] : ((b == 1) ? qb[0] : qfb[0]);
    endfunction

    task automatic wait_lvl(int b, bit v);
        while (tru(b) != v) @(negedge clk);
    endtask

    task automatic phase_len(int b, bit v, output int n);
        n = 0;
        while (tru(b) == v) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic period_of(int b, output int p);
        int h, l;
        wait_lvl(b, 1'b0);
        wait_lvl(b, 1'b1);
        phase_len(b, 1'b1, h);
        phase_len(b, 1'b0, l);
        p = h + l;
    endtask

    task automatic restart();
        @(negedge clk);
        mr = 1'b1;
        @(negedge clk);
        @(negedge clk);
        mr = 1'b0;
    endtask

    initial begin
        int n, p;
        repeat (3) @(negedge clk);
        // R4: reset state
        check(qa == 4'h0 && qb == 4'h0 && qfb == 2'h0, "R4 true outputs low", int'(qa), 0);
        check(qa_n == 4'hF && qb_n == 4'hF && qfb_n == 2'h3, "R4 complements high", int'(qa_n), 15);
        cmp_on = 1'b1;

        // R9: first tick raises every bank
        ptag = "R9";
        mr = 1'b0;
        @(negedge clk);
        check(qa[0] && qb[0] && qfb[0], "R9 aligned first edge", int'({qa[0], qb[0], qfb[0]}), 7);

        // R1 R2 R3 R8: every code, phase lengths on the oscillator
        for (int code = 0; code < 8; code++) begin
            ptag = "R8";
            sel_a = 2'(code % 4);
            sel_b = 2'((code + 1) % 4);
            sel_fb = 3'(code);
            restart();
            wait_lvl(2, 1'b1);
            phase_len(2, 1'b1, n);
            check(n == ratio_of(2, code) / 2, "R3 R8 feedback high length", n, ratio_of(2, code) / 2);
            phase_len(2, 1'b0, n);
            check(n == ratio_of(2, code) / 2, "R3 R8 feedback low length", n, ratio_of(2, code) / 2);
            period_of(0, p);
            check(p == ratio_of(0, code % 4), "R1 bank A period", p, ratio_of(0, code % 4));
            period_of(1, p);
            check(p == ratio_of(1, (code + 1) % 4), "R2 bank B period", p, ratio_of(1, (code + 1) % 4));
        end

        // R5 R6: source selection, bank A at /2
        sel_a = 2'd0;
        ptag = "R6";
        src_sel = 1'b0;
        in_sel = 1'b0;
        restart();
        period_of(0, p);
        period_of(0, p);
        check(p == 6, "R6 ref0 picked", p, 6);
        in_sel = 1'b1;
        period_of(0, p);
        period_of(0, p);
        check(p == 10, "R6 ref1 picked", p, 10);
        ptag = "R5";
        src_sel = 1'b1;
        period_of(0, p);
        period_of(0, p);
        check(p == 2, "R5 oscillator picked", p, 2);
        src_sel = 1'b0;
        period_of(0, p);
        period_of(0, p);
        check(p == 10, "R5 reference bypass", p, 10);

        // R10: select change mid-period
        ptag = "R10";
        src_sel = 1'b1;
        sel_a = 2'd3;
        restart();
        wait_lvl(0, 1'b1);
        @(negedge clk);
        sel_a = 2'd0;
        wait_lvl(0, 1'b0);
        phase_len(0, 1'b0, n);
        check(n == 4, "R10 old ratio completes", n, 4);
        phase_len(0, 1'b1, n);
        check(n == 1, "R10 new ratio after wrap", n, 1);

        // R4: reset mid-run
        ptag = "R4";
        repeat (5) @(negedge clk);
        mr = 1'b1;
        @(negedge clk);
        check(qa == 4'h0 && qb == 4'h0 && qfb == 2'h0 && qa_n == 4'hF,
              "R4 reset mid-run", int'(qa), 0);
        repeat (4) @(negedge clk);
        check(qfb_n == 2'h3 && qb_n == 4'hF, "R4 held under reset", int'(qfb_n), 3);
        mr = 1'b0;
        repeat (20) @(negedge clk);
        finish_run();
    end
endmodule